// File: doc/BRIEF.md
# Word-Serial Register Loader

This block is the loading front end of a vertical image filter. It takes one 12-bit word per clock from a host and turns a stream of words into complete writes. The targets are eight coefficient banks, four configuration registers, and sixteen each of select, round and limit registers. The storage arrays are not part of this block. It emits one write strobe together with the target type, the index inside that target and the assembled data.

A session opens when the active-low load strobe is seen going from high to low. The word taken on that same clock is an address. Its top three bits pick the target type, and the type sets how many data words follow. The low nine bits give the index. Multi-word values are gathered in a buffer and are released in a single write only when the last word has arrived. The word after that is read as the next address. A hold input freezes the sequence. Raising the load strobe ends the session and drops any burst that is only partly collected.

Top module: `wsl_loader`

## Requirements
- R1: After reset `wr_en` is low. No word is accepted until `load_n` has been sampled high at least once, even when `load_n` is held low through reset and beyond.
- R2: The word present on the clock edge that first samples `load_n` low, after a high sample, is taken as an address.
- R3: Address bits 11..9 select the type, and `wr_kind` carries the code: 3'b000 coefficient, 3'b001 configuration, 3'b011 select, 3'b101 round, 3'b111 limit.
- R4: A coefficient address is followed by 8 data words. Data word j is placed in `wr_data[12j+11:12j]`, so one set takes 9 cycles.
- R5: A configuration or select address is followed by one data word. That word appears in `wr_data[11:0]` and all higher bits are zero.
- R6: A round or limit address is followed by 4 data words. Only bits 7..0 of each word are used, and byte j goes to `wr_data[8j+7:8j]`, least significant byte first. For a limit, the lower bound is in `wr_data[15:0]` and the upper bound in `wr_data[31:16]`.
- R7: `wr_en` is high for exactly one cycle, the cycle after the edge that takes the final data word. It is never high before the burst is complete.
- R8: The word after a final data word is taken as a new address within the same session.
- R9: While `hold` is high, no word is consumed or counted, and no write is issued.
- R10: An address whose type code is undefined (010, 100, 110) is dropped, and the next word is taken as an address.
- R11: Sampling `load_n` high ends the session. A partly collected burst is discarded without any write, and the next session starts with an address.
- R12: `wr_index` equals bits 8..0 of the address word that opened the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Load strobe, active low; a falling edge opens a session |
| hold | input | 1 | Stall: the present word is neither consumed nor counted |
| word_in | input | 12 | Address or data word |
| wr_en | output | 1 | One-cycle write strobe |
| wr_kind | output | 3 | Target type code of the write |
| wr_index | output | 9 | Index inside the target |
| wr_data | output | 96 | Assembled value; the width is taps × word width |

## Verification
The bench builds the loader with its defaults: 12-bit words, eight taps and four bytes per wide value. With these values the full 96-bit coefficient assembly and the longest nine-cycle burst can be observed at the ports. The 9-bit index range can be driven up to 0x1FF, and a four-byte packing with junk in the unused upper bits of each word can be applied. Directed scenarios cover held words that must not be counted, stray type codes, and a burst cut short by release of the strobe.

// File: rtl/wsl_pkg.sv
package wsl_pkg;

    // Target type codes carried in address bits 11..9
    typedef enum logic [2:0] {
        TGT_COEF  = 3'b000,
        TGT_CFG   = 3'b001,
        TGT_SEL   = 3'b011,
        TGT_RND   = 3'b101,
        TGT_LIM   = 3'b111
    } tgt_e;

    localparam int unsigned TYPE_W  = 3;
    localparam int unsigned INDEX_W = 9;
    localparam int unsigned BYTE_W  = 8;

    // Number of data words that follow an address of the given code; 0 = undefined
    function automatic int unsigned burst_len(input logic [2:0] code,
                                              input int unsigned taps,
                                              input int unsigned nbytes);
        case (code)
            3'b000:        return taps;
            3'b001, 3'b011: return 1;
            3'b101, 3'b111: return nbytes;
            default:       return 0;
        endcase
    endfunction

endpackage

// File: rtl/wsl_session.sv
module wsl_session (
    input  logic clk,
    input  logic rst,
    input  logic load_n,
    output logic active
);
    logic prev_hi_q;   // load_n sampled high on the previous edge
    logic open_q;      // a session is already running

    assign active = !load_n && (open_q || prev_hi_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_hi_q <= 1'b0;
            open_q    <= 1'b0;
        end else begin
            prev_hi_q <= load_n;
            open_q    <= active;
        end
    end

    // R11: a high sample always closes the session
    p_release_closes_r11: assert property (@(posedge clk) disable iff (rst)
        load_n |=> !open_q);

endmodule

// File: rtl/wsl_sequencer.sv
module wsl_sequencer
    import wsl_pkg::*;
#(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned TAPS   = 8,
    parameter int unsigned NBYTES = 4,
    localparam int unsigned CNT_W = $clog2(TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              take,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              last,
    output tgt_e              kind,
    output logic [INDEX_W-1:0] index,
    output logic [CNT_W-1:0]  pos
);
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] new_len;

    assign new_len = CNT_W'(burst_len(word[WORD_W-1 -: TYPE_W], TAPS, NBYTES));
    assign last    = busy && (pos == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            busy <= 1'b0;
            pos  <= '0;
            if (rst) begin
                kind  <= TGT_COEF;
                index <= '0;
                len_q <= '0;
            end
        end else if (take) begin
            if (!busy) begin
                if (new_len != 0) begin
                    busy  <= 1'b1;
                    kind  <= tgt_e'(word[WORD_W-1 -: TYPE_W]);
                    index <= word[INDEX_W-1:0];
                    len_q <= new_len;
                    pos   <= '0;
                end
            end else if (last) begin
                busy <= 1'b0;
                pos  <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // R4: position never reaches the burst length
    p_pos_bound_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pos < len_q));

    // R9: a held word leaves the count untouched
    p_hold_freezes_r9: assert property (@(posedge clk) disable iff (rst)
        (active && !take && $past(active)) |=> $stable(pos));

endmodule

// File: rtl/wsl_assembler.sv
module wsl_assembler
    import wsl_pkg::*;
#(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned TAPS   = 8,
    parameter int unsigned NBYTES = 4,
    localparam int unsigned DATA_W = TAPS * WORD_W,
    localparam int unsigned CNT_W  = $clog2(TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  tgt_e              kind,
    input  logic [CNT_W-1:0]  pos,
    input  logic [WORD_W-1:0] word,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] buf_q;
    logic [TAPS-1:0]   lane_hit;
    logic [NBYTES-1:0] byte_hit;

    for (genvar g = 0; g < TAPS; g++) begin : g_lane
        assign lane_hit[g] = (kind == TGT_COEF) && (pos == CNT_W'(g));
    end
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_hit[b] = (kind == TGT_RND || kind == TGT_LIM) && (pos == CNT_W'(b));
    end

    always_comb begin
        merged = buf_q;
        for (int g = 0; g < TAPS; g++)
            if (lane_hit[g]) merged[g*WORD_W +: WORD_W] = word;
        for (int b = 0; b < NBYTES; b++)
            if (byte_hit[b]) merged[b*BYTE_W +: BYTE_W] = word[BYTE_W-1:0];
        if (kind == TGT_CFG || kind == TGT_SEL)
            merged[WORD_W-1:0] = word;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) buf_q <= '0;
        else if (load)    buf_q <= merged;
    end

endmodule

// File: rtl/wsl_loader.sv
module wsl_loader
    import wsl_pkg::*;
#(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned TAPS   = 8,
    parameter int unsigned NBYTES = 4,
    localparam int unsigned DATA_W = TAPS * WORD_W,
    localparam int unsigned CNT_W  = $clog2(TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              hold,
    input  logic [WORD_W-1:0] word_in,
    output logic              wr_en,
    output logic [2:0]        wr_kind,
    output logic [8:0]        wr_index,
    output logic [DATA_W-1:0] wr_data
);
    logic              active, take, busy, last;
    tgt_e              kind;
    logic [INDEX_W-1:0] index;
    logic [CNT_W-1:0]  pos;
    logic [DATA_W-1:0] merged;

    assign take = active && !hold;

    wsl_session u_session (
        .clk(clk), .rst(rst), .load_n(load_n), .active(active)
    );

    wsl_sequencer #(.WORD_W(WORD_W), .TAPS(TAPS), .NBYTES(NBYTES)) u_seq (
        .clk(clk), .rst(rst), .active(active), .take(take), .word(word_in),
        .busy(busy), .last(last), .kind(kind), .index(index), .pos(pos)
    );

    wsl_assembler #(.WORD_W(WORD_W), .TAPS(TAPS), .NBYTES(NBYTES)) u_asm (
        .clk(clk), .rst(rst), .clear(take && !busy), .load(take && busy),
        .kind(kind), .pos(pos), .word(word_in), .merged(merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en    <= 1'b0;
            wr_kind  <= '0;
            wr_index <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= take && last;
            if (take && last) begin
                wr_kind  <= kind;
                wr_index <= index;
                wr_data  <= merged;
            end
        end
    end

    // R7: the strobe never lasts two cycles (the next word must be an address)
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R11: an edge with the strobe released never commits
    p_release_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        load_n |=> !wr_en);

    // R9: a held edge never commits
    p_hold_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        hold |=> !wr_en);

    // R3: only defined type codes reach the output
    p_kind_legal_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_kind == 3'b000 || wr_kind == 3'b001 || wr_kind == 3'b011 ||
                   wr_kind == 3'b101 || wr_kind == 3'b111));

endmodule

// File: tb/wsl_loader_test.sv
`timescale 1ns/1ps
module wsl_loader_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_n = 1'b0;
    logic        hold = 1'b0;
    logic [11:0] word_in = '0;
    logic        wr_en;
    logic [2:0]  wr_kind;
    logic [8:0]  wr_index;
    logic [95:0] wr_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wsl_loader uut (
        .clk(clk), .rst(rst), .load_n(load_n), .hold(hold), .word_in(word_in),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_index(wr_index), .wr_data(wr_data)
    );

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at falling edge, return 1 ns after the next rising edge
    task automatic step(input logic ln, input logic h, input logic [11:0] w);
        @(negedge clk);
        load_n  = ln;
        hold    = h;
        word_in = w;
        @(posedge clk);
        #1;
    endtask

    task automatic quiet(input string tag);
        chk(tag, {95'd0, wr_en}, 96'd0);
    endtask

    task automatic expect_write(input string tag, input logic [2:0] k,
                                input logic [8:0] idx, input logic [95:0] d);
        chk({tag, " strobe"}, {95'd0, wr_en}, 96'd1);
        chk({tag, " kind"},   {93'd0, wr_kind}, {93'd0, k});
        chk({tag, " index"},  {87'd0, wr_index}, {87'd0, idx});
        chk({tag, " data"},   wr_data, d);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // R1: strobe low held through reset must not open a session
    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 quiet("R1 reset");
        @(negedge clk) rst = 1'b0;
        step(1'b0, 1'b0, 12'h202); quiet("R1 no session");
        step(1'b0, 1'b0, 12'h003); quiet("R1 no write");
        step(1'b0, 1'b0, 12'h003); quiet("R1 still idle");
    endtask

    // R2 R3 R4 R7 R12: coefficient set takes 9 cycles
    task automatic t_coef();
        logic [11:0] c [8] = '{12'h210, 12'h543, 12'hC76, 12'h9E3,
                               12'h701, 12'h832, 12'hF20, 12'h143};
        logic [95:0] exp = '0;
        step(1'b1, 1'b0, 12'h000);
        step(1'b0, 1'b0, 12'h00A); quiet("R2 address only");
        for (int j = 0; j < 8; j++) begin
            exp[j*12 +: 12] = c[j];
            step(1'b0, 1'b0, c[j]);
            if (j < 7) quiet("R7 early coef");
        end
        expect_write("R4 coef", 3'b000, 9'd10, exp);
    endtask

    // R5 R8 R12: configuration then select in the same session
    task automatic t_short();
        step(1'b0, 1'b0, 12'h202); quiet("R8 address");
        step(1'b0, 1'b0, 12'h003);
        expect_write("R5 cfg", 3'b001, 9'd2, 96'h003);
        step(1'b0, 1'b0, 12'h7FF); quiet("R8 next address");
        step(1'b0, 1'b0, 12'h00F);
        expect_write("R12 sel", 3'b011, 9'h1FF, 96'h00F);
    endtask

    // R6: round and limit byte packing, upper word bits ignored
    task automatic t_wide();
        step(1'b0, 1'b0, 12'hA0C);
        step(1'b0, 1'b0, 12'h5A2); step(1'b0, 1'b0, 12'h3F4);
        step(1'b0, 1'b0, 12'h983); quiet("R7 early round");
        step(1'b0, 1'b0, 12'h176);
        expect_write("R6 round", 3'b101, 9'd12, 96'h7683F4A2);
        step(1'b0, 1'b0, 12'hE07);
        step(1'b0, 1'b0, 12'h060); step(1'b0, 1'b0, 12'h03B);
        step(1'b0, 1'b0, 12'h0A4); step(1'b0, 1'b0, 12'h072);
        expect_write("R6 limit", 3'b111, 9'd7, 96'h72A43B60);
        step(1'b1, 1'b0, 12'h000); quiet("R11 release");
    endtask

    // R9: held words are neither consumed nor counted
    task automatic t_hold();
        step(1'b0, 1'b1, 12'hA05); quiet("R9 held open");
        step(1'b0, 1'b0, 12'hA05);
        step(1'b0, 1'b0, 12'h011);
        step(1'b0, 1'b1, 12'h0FF); quiet("R9 held data");
        step(1'b0, 1'b0, 12'h022);
        step(1'b0, 1'b0, 12'h033);
        step(1'b0, 1'b1, 12'h0EE); quiet("R9 held before last");
        step(1'b0, 1'b0, 12'h044);
        expect_write("R9 round", 3'b101, 9'd5, 96'h44332211);
    endtask

    // R10: undefined type codes dropped
    task automatic t_bad();
        step(1'b0, 1'b0, 12'h400); quiet("R10 code 010");
        step(1'b0, 1'b0, 12'h8FF); quiet("R10 code 100");
        step(1'b0, 1'b0, 12'h203); quiet("R10 address");
        step(1'b0, 1'b0, 12'h055);
        expect_write("R10 cfg", 3'b001, 9'd3, 96'h055);
        step(1'b1, 1'b0, 12'h000);
    endtask

    // R11: released strobe discards a partial burst
    task automatic t_abandon();
        step(1'b0, 1'b0, 12'h003);
        step(1'b0, 1'b0, 12'h111); step(1'b0, 1'b0, 12'h222);
        step(1'b0, 1'b0, 12'h333); quiet("R11 partial");
        step(1'b1, 1'b0, 12'h444); quiet("R11 released");
        step(1'b0, 1'b0, 12'h201); quiet("R11 new address");
        step(1'b0, 1'b0, 12'h7AB);
        expect_write("R11 cfg", 3'b001, 9'd1, 96'h7AB);
        step(1'b1, 1'b0, 12'h000); quiet("R11 end");
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        t_reset();
        t_coef();
        t_short();
        t_wide();
        t_hold();
        t_bad();
        t_abandon();
        report();
    end

endmodule